// File: doc/BRIEF.md
# Hot-Plug Slot Controller

This block holds the slot control and slot status registers of a hot-plug capable downstream port and turns slot events into interrupts. Software programs the control register through a byte-enabled register write port. Every control write is treated as one command and is acknowledged by a command-done event. Status events are cleared by writing ones. The slot side supplies three inputs: an attention button pulse, a device-arrival pulse that carries a boot-time flag, and a device-present level that is sampled at reset.

The block asserts an interrupt condition while hot-plug interrupts are enabled and at least one status event is set whose own enable is also set. When message interrupts are selected, a rise of that condition produces a one-cycle request that carries a 5-bit vector. Otherwise a registered legacy line follows the condition. The indicator and power-control fields drive output pins directly. A control write that selects power off with the power indicator off detaches a present device.

Control register layout: bit0 button-event enable, bit1 presence-change enable, bit2 command-done enable, bit3 hot-plug interrupt enable, bits5:4 attention indicator, bits7:6 power indicator, bit8 power off, bit9 lock toggle. Status register layout: bit0 button event, bit1 presence changed, bit2 command done, bit3 presence state, bit4 lock state. Indicator codes are 01 on, 10 blink and 11 off. Byte enable bit b covers data bits 8b+7 to 8b.

Top module: `hp_slot_ctrl`

## Requirements
- R1: The interrupt condition is true when the hot-plug interrupt enable (control bit3) is 1 and, for some i in 0..2, both status bit i and control bit i are 1.
- R2: With msg_en high, each 0-to-1 change of the interrupt condition produces exactly one single-cycle msg_req, one cycle after the status change, with msg_vec equal to vec_cfg. Setting an event that is already set produces no new request.
- R3: intx is the interrupt condition registered one cycle while msg_en is low, and it is 0 while msg_en is high.
- R4: A control write with byte enable 1 set and data bit9 set toggles the lock state (status bit4). Control bit9 always reads 0.
- R5: A write to the control register with any byte enable set counts as one command. Only the enabled bytes update. The command-done event (status bit2) is set in the next cycle. A write with no byte enable set changes nothing.
- R6: A control write whose resulting value has power off (bit8) set and power indicator 11 detaches the device while presence state is 1. Presence state is cleared and presence changed (status bit1) is set.
- R7: A device-arrival pulse with add_boot low sets presence state, presence changed and the button event. With add_boot high it sets only presence state.
- R8: Reset clears the enables and the lock state, all event bits and the lock toggle, and sets the attention indicator to 11.
- R9: With power control present, reset sets power off to 0 and the power indicator to 01 if present_in is 1, and sets power off to 1 and the power indicator to 11 if present_in is 0. Presence state takes the value of present_in.
- R10: Status bits 2:0 clear when written with 1. Presence state and lock state ignore status writes. intx drops one cycle after the last enabled pending event is cleared.
- R11: A device-arrival pulse while the lock state is 1 gives a one-cycle busy_err in the next cycle and leaves the status unchanged.
- R12: An attention button pulse sets the button event (status bit0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control, 1 status |
| wr_be | input | 2 | Byte enables of the write |
| wr_data | input | 16 | Write data |
| rd_sel | input | 1 | Read select: 0 control, 1 status |
| rd_data | output | 16 | Selected register, registered one cycle |
| btn_press | input | 1 | Attention button pulse |
| add_pulse | input | 1 | Device-arrival pulse |
| add_boot | input | 1 | Arrival belongs to boot time |
| present_in | input | 1 | Device-present level, sampled at reset |
| msg_en | input | 1 | Message interrupts selected |
| vec_cfg | input | 5 | Interrupt message number |
| intx | output | 1 | Legacy interrupt level |
| msg_req | output | 1 | Message interrupt request pulse |
| msg_vec | output | 5 | Vector of the last message request |
| busy_err | output | 1 | Arrival rejected because the slot is locked |
| attn_ind | output | 2 | Attention indicator state |
| pwr_ind | output | 2 | Power indicator state |
| pwr_off | output | 1 | Power controller off |

## Verification
On every cycle, the assertions check that a message request never lasts two cycles and never overlaps the legacy line, that every counted command is followed by command done, that a lock toggle write flips the lock state, that a locked arrival raises busy and leaves presence unchanged, and that the attention indicator is off after reset. Only the bench scenarios can show the rest: the exact interrupt condition across enable combinations, the absence of a second message for an already-set event, the byte-lane merging, detach on a power-off command, hot-add with and without the boot flag, and both reset variants that depend on presence.

// File: rtl/hp_slot_pkg.sv
package hp_slot_pkg;
  localparam int REG_W   = 16;
  localparam int BE_W    = REG_W / 8;
  localparam int NUM_EVT = 3;
  localparam int IND_W   = 2;

  localparam logic [IND_W-1:0] IND_ON    = 2'b01;
  localparam logic [IND_W-1:0] IND_BLINK = 2'b10;
  localparam logic [IND_W-1:0] IND_OFF   = 2'b11;

  // control fields
  localparam int C_BTN_EN  = 0;
  localparam int C_PRES_EN = 1;
  localparam int C_CC_EN   = 2;
  localparam int C_HPIE    = 3;
  localparam int C_ATTN    = 4;
  localparam int C_PIND    = 6;
  localparam int C_POFF    = 8;
  localparam int C_LOCK    = 9;

  // status fields
  localparam int S_BTN  = 0;
  localparam int S_PCHG = 1;
  localparam int S_CMD  = 2;
  localparam int S_PRES = 3;
  localparam int S_LOCK = 4;
endpackage

// File: rtl/hp_ctl_reg.sv
module hp_ctl_reg
  import hp_slot_pkg::*;
#(
  parameter bit HAS_PWR_CTL = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             present_in,
  input  logic             wr_ctl,
  input  logic [REG_W-1:0] wr_data,
  input  logic [BE_W-1:0]  wr_be,
  input  logic             pres_state,
  output logic [REG_W-1:0] ctl_q,
  output logic             lock_tgl,
  output logic             detach
);
  localparam logic [REG_W-1:0] STORE_MASK = REG_W'((1 << C_LOCK) - 1);

  logic [REG_W-1:0] lane_mask;
  logic [REG_W-1:0] merged;
  logic [REG_W-1:0] rst_val;

  always_comb begin
    for (int b = 0; b < BE_W; b++) lane_mask[b*8 +: 8] = {8{wr_be[b]}};
    merged   = (ctl_q & ~lane_mask) | (wr_data & lane_mask & STORE_MASK);
    lock_tgl = wr_ctl & wr_be[C_LOCK/8] & wr_data[C_LOCK];
    detach   = wr_ctl & pres_state & merged[C_POFF] &
               (merged[C_PIND +: IND_W] == IND_OFF);
  end

  generate
    if (HAS_PWR_CTL) begin : g_pwr
      always_comb begin
        rst_val                   = '0;
        rst_val[C_ATTN +: IND_W]  = IND_OFF;
        rst_val[C_PIND +: IND_W]  = present_in ? IND_ON : IND_OFF;
        rst_val[C_POFF]           = ~present_in;
      end
    end else begin : g_nopwr
      always_comb begin
        rst_val                   = '0;
        rst_val[C_ATTN +: IND_W]  = IND_OFF;
        rst_val[C_PIND +: IND_W]  = IND_OFF;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)         ctl_q <= rst_val;
    else if (wr_ctl) ctl_q <= merged;
  end
endmodule

// File: rtl/hp_sts_reg.sv
module hp_sts_reg
  import hp_slot_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               present_in,
  input  logic               wr_sts,
  input  logic [NUM_EVT-1:0] clr_bits,
  input  logic               wr_ctl,
  input  logic               lock_tgl,
  input  logic               detach,
  input  logic               btn_press,
  input  logic               add_pulse,
  input  logic               add_boot,
  output logic [REG_W-1:0]   sts_q,
  output logic               busy_err
);
  logic btn_q, pchg_q, cmd_q, pres_q, lock_q;
  logic add_ok, add_hot;
  logic [NUM_EVT-1:0] clr;

  always_comb begin
    add_ok  = add_pulse & ~lock_q;
    add_hot = add_ok & ~add_boot;
    clr     = wr_sts ? clr_bits : '0;
    sts_q         = '0;
    sts_q[S_BTN]  = btn_q;
    sts_q[S_PCHG] = pchg_q;
    sts_q[S_CMD]  = cmd_q;
    sts_q[S_PRES] = pres_q;
    sts_q[S_LOCK] = lock_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      btn_q    <= 1'b0;
      pchg_q   <= 1'b0;
      cmd_q    <= 1'b0;
      pres_q   <= present_in;
      lock_q   <= 1'b0;
      busy_err <= 1'b0;
    end else begin
      btn_q    <= (btn_q  & ~clr[S_BTN])  | btn_press | add_hot;
      pchg_q   <= (pchg_q & ~clr[S_PCHG]) | add_hot | detach;
      cmd_q    <= (cmd_q  & ~clr[S_CMD])  | wr_ctl;
      pres_q   <= add_ok ? 1'b1 : (detach ? 1'b0 : pres_q);
      lock_q   <= lock_q ^ lock_tgl;
      busy_err <= add_pulse & lock_q;
    end
  end
endmodule

// File: rtl/hp_notify.sv
module hp_notify
  import hp_slot_pkg::*;
#(
  parameter int VEC_W = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_EVT-1:0] evt_sts,
  input  logic [NUM_EVT-1:0] evt_en,
  input  logic               hp_ie,
  input  logic               msg_en,
  input  logic [VEC_W-1:0]   vec_cfg,
  output logic               intx,
  output logic               msg_req,
  output logic [VEC_W-1:0]   msg_vec
);
  logic pend_now, pend_q, rise;

  always_comb begin
    pend_now = hp_ie & (|(evt_sts & evt_en));
    rise     = pend_now & ~pend_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= 1'b0;
      intx    <= 1'b0;
      msg_req <= 1'b0;
      msg_vec <= '0;
    end else begin
      pend_q  <= pend_now;
      intx    <= pend_now & ~msg_en;
      msg_req <= rise & msg_en;
      if (rise & msg_en) msg_vec <= vec_cfg;
    end
  end
endmodule

// File: rtl/hp_slot_ctrl.sv
module hp_slot_ctrl
  import hp_slot_pkg::*;
#(
  parameter bit HAS_PWR_CTL = 1'b1,
  parameter int VEC_W       = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [BE_W-1:0]  wr_be,
  input  logic [REG_W-1:0] wr_data,
  input  logic             rd_sel,
  output logic [REG_W-1:0] rd_data,
  input  logic             btn_press,
  input  logic             add_pulse,
  input  logic             add_boot,
  input  logic             present_in,
  input  logic             msg_en,
  input  logic [VEC_W-1:0] vec_cfg,
  output logic             intx,
  output logic             msg_req,
  output logic [VEC_W-1:0] msg_vec,
  output logic             busy_err,
  output logic [IND_W-1:0] attn_ind,
  output logic [IND_W-1:0] pwr_ind,
  output logic             pwr_off
);
  logic [REG_W-1:0]   ctl_q, sts_q;
  logic               wr_ctl, wr_sts, lock_tgl, detach;
  logic [NUM_EVT-1:0] clr_bits;

  always_comb begin
    wr_ctl   = wr_en & ~wr_sel & (|wr_be);
    wr_sts   = wr_en & wr_sel;
    clr_bits = wr_data[NUM_EVT-1:0] & {NUM_EVT{wr_be[0]}};
  end

  hp_ctl_reg #(.HAS_PWR_CTL(HAS_PWR_CTL)) u_ctl (
    .clk(clk), .rst(rst), .present_in(present_in), .wr_ctl(wr_ctl),
    .wr_data(wr_data), .wr_be(wr_be), .pres_state(sts_q[S_PRES]),
    .ctl_q(ctl_q), .lock_tgl(lock_tgl), .detach(detach)
  );

  hp_sts_reg u_sts (
    .clk(clk), .rst(rst), .present_in(present_in), .wr_sts(wr_sts),
    .clr_bits(clr_bits), .wr_ctl(wr_ctl), .lock_tgl(lock_tgl),
    .detach(detach), .btn_press(btn_press), .add_pulse(add_pulse),
    .add_boot(add_boot), .sts_q(sts_q), .busy_err(busy_err)
  );

  hp_notify #(.VEC_W(VEC_W)) u_ntf (
    .clk(clk), .rst(rst), .evt_sts(sts_q[NUM_EVT-1:0]),
    .evt_en(ctl_q[NUM_EVT-1:0]), .hp_ie(ctl_q[C_HPIE]), .msg_en(msg_en),
    .vec_cfg(vec_cfg), .intx(intx), .msg_req(msg_req), .msg_vec(msg_vec)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_sel ? sts_q : ctl_q;
  end

  always_comb begin
    attn_ind = ctl_q[C_ATTN +: IND_W];
    pwr_ind  = ctl_q[C_PIND +: IND_W];
    pwr_off  = ctl_q[C_POFF];
  end
endmodule

// File: rtl/hp_slot_chk.sv
module hp_slot_chk
  import hp_slot_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic             wr_sel,
  input logic [BE_W-1:0]  wr_be,
  input logic             lock_bit,
  input logic             add_pulse,
  input logic             msg_req,
  input logic             intx,
  input logic             busy_err,
  input logic [IND_W-1:0] attn_ind,
  input logic [REG_W-1:0] sts_q
);
  AST_MSG_PULSE: assert property (@(posedge clk) disable iff (rst)
    msg_req |=> !msg_req); // R2

  AST_MSG_NOT_INTX: assert property (@(posedge clk) disable iff (rst)
    msg_req |-> !intx); // R3

  AST_LOCK_TOGGLE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_sel && wr_be[C_LOCK/8] && lock_bit)
      |=> (sts_q[S_LOCK] != $past(sts_q[S_LOCK]))); // R4

  AST_CMD_DONE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_sel && (|wr_be)) |=> sts_q[S_CMD]); // R5

  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (add_pulse && sts_q[S_LOCK] && !(wr_en && !wr_sel))
      |=> (busy_err && (sts_q[S_PRES] == $past(sts_q[S_PRES])))); // R11

  AST_RST_ATTN_OFF: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (attn_ind == IND_OFF)); // R8
endmodule

bind hp_slot_ctrl hp_slot_chk u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_be(wr_be),
  .lock_bit(wr_data[hp_slot_pkg::C_LOCK]), .add_pulse(add_pulse),
  .msg_req(msg_req), .intx(intx), .busy_err(busy_err),
  .attn_ind(attn_ind), .sts_q(sts_q)
);

// File: tb/sim_hp_slot_ctrl.sv
`timescale 1ns/1ps
module sim_hp_slot_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
  logic [1:0]  wr_be = 2'b00;
  logic [15:0] wr_data = 16'h0;
  logic        btn_press = 1'b0, add_pulse = 1'b0, add_boot = 1'b0;
  logic        present_in = 1'b1, msg_en = 1'b0;
  logic [4:0]  vec_cfg = 5'd0;
  logic [15:0] rd_data;
  logic        intx, msg_req, busy_err, pwr_off;
  logic [4:0]  msg_vec;
  logic [1:0]  attn_ind, pwr_ind;

  integer checks = 0, failures = 0, msg_cnt = 0, busy_cnt = 0;
  logic   done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hp_slot_ctrl u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_be(wr_be),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .btn_press(btn_press), .add_pulse(add_pulse), .add_boot(add_boot),
    .present_in(present_in), .msg_en(msg_en), .vec_cfg(vec_cfg),
    .intx(intx), .msg_req(msg_req), .msg_vec(msg_vec), .busy_err(busy_err),
    .attn_ind(attn_ind), .pwr_ind(pwr_ind), .pwr_off(pwr_off)
  );

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  logic [2:0]  m_en, m_ev;
  logic        m_hpie, m_poff, m_ps, m_lock, m_pend, m_intx, m_msg, m_busy;
  logic [1:0]  m_attn, m_pind;
  logic [4:0]  m_vec;
  logic [15:0] m_rd;
  logic        m_on = 1'b0;

  always @(posedge clk) begin
    logic pend_now, cw, sw, tog, det, addok, hot;
    logic [2:0] clr;
    if (rst) begin
      m_en = 0; m_hpie = 0; m_attn = 2'b11;
      m_pind = present_in ? 2'b01 : 2'b11; m_poff = !present_in;
      m_ev = 0; m_ps = present_in; m_lock = 0;
      m_pend = 0; m_intx = 0; m_msg = 0; m_vec = 0; m_busy = 0; m_rd = 0;
      m_on = 1'b1;
    end else begin
      pend_now = m_hpie && ((m_ev & m_en) != 3'b000);
      m_rd = rd_sel ? {11'b0, m_lock, m_ps, m_ev}
                    : {7'b0, m_poff, m_pind, m_attn, m_hpie, m_en};
      m_msg = msg_en && pend_now && !m_pend;
      if (m_msg) m_vec = vec_cfg;
      m_intx = pend_now && !msg_en;
      m_pend = pend_now;
      m_busy = add_pulse && m_lock;
      cw = wr_en && !wr_sel && (wr_be != 2'b00);
      sw = wr_en && wr_sel;
      if (cw && wr_be[0]) begin
        m_en = wr_data[2:0]; m_hpie = wr_data[3];
        m_attn = wr_data[5:4]; m_pind = wr_data[7:6];
      end
      if (cw && wr_be[1]) m_poff = wr_data[8];
      tog   = cw && wr_be[1] && wr_data[9];
      det   = cw && m_ps && m_poff && (m_pind == 2'b11);
      addok = add_pulse && !m_lock;
      hot   = addok && !add_boot;
      clr   = (sw && wr_be[0]) ? wr_data[2:0] : 3'b000;
      m_ev[0] = (m_ev[0] && !clr[0]) || btn_press || hot;
      m_ev[1] = (m_ev[1] && !clr[1]) || hot || det;
      m_ev[2] = (m_ev[2] && !clr[2]) || cw;
      if (addok) m_ps = 1'b1; else if (det) m_ps = 1'b0;
      m_lock = m_lock ^ tog;
    end
  end

  always @(negedge clk) begin
    if (m_on && !done) begin
      chk("R3", "intx model", {15'b0, intx}, {15'b0, m_intx});
      chk("R2", "msg_req model", {15'b0, msg_req}, {15'b0, m_msg});
      chk("R2", "msg_vec model", {11'b0, msg_vec}, {11'b0, m_vec});
      chk("R11", "busy model", {15'b0, busy_err}, {15'b0, m_busy});
      chk("R8", "attn model", {14'b0, attn_ind}, {14'b0, m_attn});
      chk("R9", "pwr_ind model", {14'b0, pwr_ind}, {14'b0, m_pind});
      chk("R9", "pwr_off model", {15'b0, pwr_off}, {15'b0, m_poff});
      chk("R5", "rd_data model", rd_data, m_rd);
    end
    if (msg_req) msg_cnt++;
    if (busy_err) busy_cnt++;
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic sel, input logic [1:0] be, input logic [15:0] d);
    @(negedge clk); wr_en = 1; wr_sel = sel; wr_be = be; wr_data = d;
    @(negedge clk); wr_en = 0; wr_be = 2'b00; wr_data = 16'h0;
  endtask

  task automatic press();
    @(negedge clk); btn_press = 1;
    @(negedge clk); btn_press = 0;
  endtask

  task automatic hot_add(input logic boot);
    @(negedge clk); add_pulse = 1; add_boot = boot;
    @(negedge clk); add_pulse = 0; add_boot = 0;
  endtask

  task automatic rd(input logic sel, output logic [15:0] v);
    rd_sel = sel; idle(2); v = rd_data;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1; idle(3); rst = 0; idle(1);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired");
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    logic [15:0] v;
    integer c0;
    idle(3); rst = 0; idle(1);
    // R8 R9: populated reset
    rd(0, v); chk("R8", "ctl after reset", v, 16'h0070);
    rd(1, v); chk("R9", "sts after reset", v, 16'h0008);
    chk("R9", "pwr_ind populated", {14'b0, pwr_ind}, 16'h0001);
    // R5 R1 R3: enable all, command completes, legacy line rises
    wr(0, 2'b01, 16'h007F); idle(1);
    chk("R5", "intx after command", {15'b0, intx}, 16'h0001);
    rd(1, v); chk("R5", "cmd done set", v, 16'h000C);
    // R10: clear, presence bit ignores write
    wr(1, 2'b01, 16'h000C); idle(1);
    chk("R10", "intx after clear", {15'b0, intx}, 16'h0000);
    rd(1, v); chk("R10", "sts after w1c", v, 16'h0008);
    // R12 R1
    press(); idle(1);
    chk("R12", "intx after button", {15'b0, intx}, 16'h0001);
    wr(0, 2'b01, 16'h0077); idle(1);
    chk("R1", "intx with hpie off", {15'b0, intx}, 16'h0000);
    rd(1, v); chk("R12", "button and cmd", v, 16'h000D);
    wr(1, 2'b01, 16'h0007);
    wr(0, 2'b01, 16'h007F); wr(1, 2'b01, 16'h0007); idle(2);
    // R2: message mode
    msg_en = 1; vec_cfg = 5'd19; idle(2);
    c0 = msg_cnt; press(); idle(3);
    chk("R2", "one message", 16'(msg_cnt - c0), 16'h0001);
    chk("R2", "message vector", {11'b0, msg_vec}, 16'd19);
    chk("R3", "intx quiet in msg mode", {15'b0, intx}, 16'h0000);
    c0 = msg_cnt; press(); idle(3);
    chk("R2", "no message on re-set", 16'(msg_cnt - c0), 16'h0000);
    // R4: lock toggle
    wr(0, 2'b10, 16'h0200);
    rd(1, v); chk("R4", "lock set", v, 16'h001D);
    rd(0, v); chk("R4", "toggle reads 0", v, 16'h007F);
    // R11: locked hot-add
    c0 = busy_cnt; hot_add(1'b0); idle(2);
    chk("R11", "busy pulse", 16'(busy_cnt - c0), 16'h0001);
    rd(1, v); chk("R11", "status unchanged", v, 16'h001D);
    wr(0, 2'b10, 16'h0200);
    rd(1, v); chk("R4", "lock cleared", v, 16'h000D);
    wr(1, 2'b01, 16'h0007); msg_en = 0; idle(2);
    // R6: detach
    wr(0, 2'b11, 16'h01FF);
    rd(1, v); chk("R6", "detach status", v, 16'h0006);
    chk("R6", "pwr_off after detach", {15'b0, pwr_off}, 16'h0001);
    wr(1, 2'b01, 16'h0007);
    // R7
    hot_add(1'b1);
    rd(1, v); chk("R7", "boot add", v, 16'h0008);
    hot_add(1'b0);
    rd(1, v); chk("R7", "hot add", v, 16'h000B);
    // R5 byte lanes
    wr(0, 2'b00, 16'hFFFF);
    rd(0, v); chk("R5", "no-lane ctl", v, 16'h01FF);
    rd(1, v); chk("R5", "no-lane sts", v, 16'h000B);
    wr(0, 2'b01, 16'h0000);
    rd(0, v); chk("R5", "low lane ctl", v, 16'h0100);
    rd(1, v); chk("R5", "low lane sts", v, 16'h000F);
    // R8 R9: empty reset releases lock
    wr(0, 2'b10, 16'h0300);
    present_in = 0; do_reset();
    rd(1, v); chk("R8", "sts empty reset", v, 16'h0000);
    rd(0, v); chk("R9", "ctl empty reset", v, 16'h01F0);
    chk("R9", "pwr_off empty", {15'b0, pwr_off}, 16'h0001);
    idle(2);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule